// File: doc/BRIEF.md
# Write-Edge Acceptance Filter

This block sits between a 6502-style CPU bus and the serial control port of a cartridge mapper. It decides which CPU write cycles reach that port. A write counts only when the read/write line drops from read to write while the port is selected. Every further write cycle in the same unbroken low run of the read/write line is dropped.

The filtering matters for read-modify-write instructions. An increment-memory instruction issues two write cycles in a row to the same address with no read cycle between them. The first carries the old value and the second carries the new one, for example 0xFF and then 0x00. Only the first of the pair is passed to the port. The next opcode fetch is a read cycle, and that read re-arms the filter.

The read/write line is sampled once per CPU clock, on the rising edge. Each accepted write produces a one-clock strobe in the cycle after the write cycle. The data byte of that write is registered in the same edge that raises the strobe.

Top module: `wef_top`

## Requirements
- R1: While reset is high, and at the first falling clock edge after it, `wr_accept_o` is 0 and `wr_data_o` is 0.
- R2: A write is accepted when the sampled `cpu_rw_i` is 0 (write) in a cycle after a sampled 1 (read), and `port_sel_i` is 1 in that cycle. `wr_accept_o` is then 1 for exactly one clock, in the cycle that follows the write cycle.
- R3: When a write is accepted, `wr_data_o` takes the `cpu_data_i` value of the accepted write cycle, in the same clock that `wr_accept_o` goes high.
- R4: A write cycle that directly follows another write cycle, with `cpu_rw_i` held at 0 between them, is never accepted. For an increment-style pair (0xFF then 0x00), `wr_data_o` keeps 0xFF.
- R5: Two selected writes separated by a single read cycle are both accepted, and `wr_data_o` ends with the second value.
- R6: A write cycle that starts a low run while `port_sel_i` is 0 is not accepted. A following write cycle in the same low run is also rejected, even if it selects the port.
- R7: The filter comes out of reset as if the last cycle were a read, so a selected write in the first cycle after reset is accepted.
- R8: In any cycle without an accept, `wr_data_o` keeps its previous value.
- R9: A read cycle never produces an accept, whether or not `port_sel_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rw_i | input | 1 | Bus direction: 1 = read cycle, 0 = write cycle |
| port_sel_i | input | 1 | Address decode: 1 when the cycle targets the control port |
| cpu_data_i | input | DATA_W | CPU data bus |
| wr_accept_o | output | 1 | One-clock strobe for each accepted write |
| wr_data_o | output | DATA_W | Data byte of the most recent accepted write |

## Verification
The filter is driven through every sequence of four cycles built from the four combinations of direction and select. Each sequence carries distinct data, so a dropped second write shows up as a stale byte rather than a missing strobe alone. Directed runs cover the plain single write, the increment-style pair, a write–read–write pattern and a write that starts unselected. Together these separate acceptance on the falling transition from acceptance on a low level, and show where the select decode is sampled. A selected write in the first cycle after reset shows that the edge flop starts in the read state.

// File: rtl/wef_pkg.sv
package wef_pkg;
  parameter int unsigned WEF_DATA_W = 8;
  localparam logic RW_READ  = 1'b1;
  localparam logic RW_WRITE = 1'b0;
endpackage

// File: rtl/wef_rw_tracker.sv
module wef_rw_tracker
  import wef_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rw_i,
  output logic fall_o
);
  logic prev_q;
  logic past_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= RW_READ;
      past_ok_q <= 1'b0;
    end else begin
      prev_q    <= rw_i;
      past_ok_q <= 1'b1;
    end
  end

  assign fall_o = (prev_q == RW_READ) && (rw_i == RW_WRITE);

  AST_NO_FALL_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && $past(rw_i) == RW_WRITE) |-> !fall_o); // R4

  AST_NO_FALL_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rw_i == RW_READ) |-> !fall_o); // R9
endmodule

// File: rtl/wef_accept.sv
module wef_accept (
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic sel_i,
  output logic strobe_o
);
  always_ff @(posedge clk) begin
    if (rst) strobe_o <= 1'b0;
    else     strobe_o <= fall_i && sel_i;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o); // R2

  AST_PULSE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (!sel_i) |=> !strobe_o); // R6
endmodule

// File: rtl/wef_data_reg.sv
module wef_data_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/wef_top.sv
module wef_top
  import wef_pkg::*;
#(
  parameter int unsigned DATA_W = WEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rw_i,
  input  logic              port_sel_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  output logic              wr_accept_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic fall;
  logic load;

  wef_rw_tracker u_track (
    .clk    (clk),
    .rst    (rst),
    .rw_i   (cpu_rw_i),
    .fall_o (fall)
  );

  wef_accept u_accept (
    .clk      (clk),
    .rst      (rst),
    .fall_i   (fall),
    .sel_i    (port_sel_i),
    .strobe_o (wr_accept_o)
  );

  assign load = fall && port_sel_i;

  wef_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .d_i    (cpu_data_i),
    .q_o    (wr_data_o)
  );

  AST_DATA_MATCH: assert property (@(posedge clk) disable iff (rst)
    (port_sel_i && cpu_rw_i == RW_WRITE) |=> (!wr_accept_o || wr_data_o == $past(cpu_data_i))); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_accept_o |-> $stable(wr_data_o)); // R8

  AST_READ_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (cpu_rw_i == RW_READ) |=> !wr_accept_o); // R9
endmodule

// File: tb/test_wef_top.sv
module test_wef_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       rw;
  logic       sel;
  logic [7:0] din;
  logic       strobe;
  logic [7:0] dout;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic       m_prev;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  wef_top #(.DATA_W(8)) i_wef_top (
    .clk         (clk),
    .rst         (rst),
    .cpu_rw_i    (rw),
    .port_sel_i  (sel),
    .cpu_data_i  (din),
    .wr_accept_o (strobe),
    .wr_data_o   (dout)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at falling edge, sample at the next falling edge
  task automatic step(input logic r, input logic s, input logic [7:0] d);
    logic  exp_s;
    string ts;
    rw = r; sel = s; din = d;
    @(posedge clk);
    exp_s = m_prev && !r && s;
    if (exp_s)                 ts = "R2";
    else if (r)                ts = "R9";
    else if (!m_prev)          ts = "R4";
    else                       ts = "R6";
    if (exp_s) m_data = d;
    m_prev = r;
    @(negedge clk);
    check(ts, {7'd0, strobe}, {7'd0, exp_s});
    check(exp_s ? "R3" : "R8", dout, m_data);
  endtask

  task automatic do_reset();
    rst = 1'b1; rw = 1'b1; sel = 1'b0; din = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", {7'd0, strobe}, 8'd0);
    check("R1", dout, 8'd0);
    m_prev = 1'b1; m_data = 8'h00;
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R7: selected write in first cycle after reset
    step(1'b0, 1'b1, 8'h5A);
    check("R7", dout, 8'h5A);
    step(1'b1, 1'b0, 8'h00);

    // single write
    step(1'b1, 1'b1, 8'h11);
    step(1'b0, 1'b1, 8'h22);
    step(1'b1, 1'b0, 8'h00);
    check("R2", dout, 8'h22);

    // R4: increment-style dummy then real write
    step(1'b0, 1'b1, 8'hFF);
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b1, 8'h77);
    check("R4", dout, 8'hFF);

    // R5: write, one read, write
    step(1'b0, 1'b1, 8'h31);
    step(1'b1, 1'b1, 8'h99);
    step(1'b0, 1'b1, 8'h32);
    step(1'b1, 1'b0, 8'h00);
    check("R5", dout, 8'h32);

    // R6: unselected edge, then selected write in same low run
    step(1'b0, 1'b0, 8'hA0);
    step(1'b0, 1'b1, 8'hA1);
    step(1'b1, 1'b0, 8'h00);
    check("R6", dout, 8'h32);

    // sweep every 4-cycle pattern of (rw, sel)
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [1:0] pat;
        pat = 2'((i >> (2 * k)) & 3);
        step(pat[1], pat[0], 8'((i * 53 + k * 17 + 1) & 8'hFF));
      end
    end

    do_reset();
    step(1'b0, 1'b1, 8'hC3); // R7 after second reset
    check("R7", dout, 8'hC3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule